// File: doc/BRIEF.md
# Command Word Collector and Dispatcher

This block sits in front of a drawing engine and gathers 32-bit command words into a queue. The top byte of the oldest queued word is the opcode. It selects how many words the packet needs. Once enough words are present, the block removes them, raises a single-cycle execute strobe with the opcode and the first packet words, and goes on to the next packet. Packets that are longer than the strobe can carry pass their remaining words out one per cycle on a separate tail stream. For a pixel upload, the size field in the third word gives the number of payload words.

A pixel readout command halts all dispatch until the readout engine signals completion. The two status outputs follow the internal state and not the queue fill level. A side command with code 0x01 empties the queue and returns the block to idle. The packet length of a draw primitive comes from an external lookup. The block shows the current head opcode to that lookup and receives the length back in the same cycle.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset, `in_ready`, `cmd_ready` and `dma_ready` are 1, and `exec_valid` and `tail_valid` are 0.
- R2: Packet length depends on the opcode in bits 31:24 of the first word. Opcode 0x02 (fill) takes 3 words. Opcodes with top bits 100 (copy) take 4 words. Top bits 110 (readout) take 3 words. Top bits 101 (upload) take 3 header words plus a payload. Top bits 001, 010 or 011 (draw) take `prim_len` words, where 0 counts as 1. Every other opcode takes 1 word, including 0x00 and 0x01.
- R3: `exec_valid` is a registered one-cycle strobe for each packet, issued in queue order. It fires only when the whole packet is queued; for an upload, only the 3 header words need to be queued. `exec_op` is the opcode. Slot i of `exec_words` (bits 32i+31:32i) holds packet word i for i < min(length, 4), or 3 header words for an upload; all other slots are zero.
- R4: While an incomplete packet waits in the queue, `cmd_ready` is 0, `dma_ready` is 1, the queued words are kept, and nothing executes.
- R5: An upload payload has (w*h+1)/2 words. Here w is bits 9:0 of header word 2, with 0 meaning 1024, and h is bits 24:16, with 0 meaning 512; the other bits of that word are ignored. The payload words leave on `tail_word` in order, one per cycle with `tail_valid`, as soon as they are queued. The block then returns to idle.
- R6: For a draw packet longer than 4 words, words 4 to length-1 leave on the tail stream in order after the strobe.
- R7: After a readout strobe, `cmd_ready` and `dma_ready` are 0 and no strobe or tail word is produced until `rd_done` is seen. After that, queued words dispatch again.
- R8: When DEPTH words are queued, `in_ready` is 0, and no accepted word is lost or reordered.
- R9: A side command with code 0x01 empties the queue, discarding any partial packet, and returns to idle with `cmd_ready` and `dma_ready` at 1. Any other side code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 32 | Command word |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Queue can take a word |
| side_valid | input | 1 | Side command strobe |
| side_code | input | 8 | Side command code |
| head_op | output | 8 | Opcode of the oldest queued word, for the length lookup |
| prim_len | input | PLEN_W | Draw packet length for `head_op` |
| rd_done | input | 1 | Readout engine finished |
| exec_valid | output | 1 | Execute strobe |
| exec_op | output | 8 | Opcode of the executed packet |
| exec_words | output | SLOTS*32 | First packet words, slot i at bits 32i+31:32i |
| tail_valid | output | 1 | Tail word valid |
| tail_word | output | 32 | Upload payload word or draw tail word |
| cmd_ready | output | 1 | Ready for a new command |
| dma_ready | output | 1 | Ready for block-transfer words |

## Verification
The bench builds the block with DEPTH=16, SLOTS=4 and PLEN_W=4. A 16-word queue fills within a few cycles of a readout stall, so back-pressure and pointer wrap-around occur often. Draw lengths up to 15 come close to filling the queue and send words past slot 3 onto the tail stream. Upload sizes with a zero width or height field yield 512- and 768-word payloads, which cycle through the small queue many times.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int TOT_W = 20;

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_EXE, ST_RD, ST_WR} st_e;
  typedef enum logic [2:0] {K_ONE, K_FILL, K_COPY, K_DRAW, K_UP, K_RD} kind_e;

  function automatic kind_e op_kind(input logic [7:0] op);
    kind_e k;
    if (op[7:5] == 3'b001 || op[7:5] == 3'b010 || op[7:5] == 3'b011) k = K_DRAW;
    else if (op[7:5] == 3'b100) k = K_COPY;
    else if (op[7:5] == 3'b101) k = K_UP;
    else if (op[7:5] == 3'b110) k = K_RD;
    else if (op == 8'h02) k = K_FILL;
    else k = K_ONE;
    return k;
  endfunction

  // payload words of an upload: half the pixel count, rounded up
  function automatic logic [TOT_W-1:0] up_payload(input logic [31:0] sz);
    logic [20:0] w;
    logic [20:0] h;
    logic [20:0] px;
    w  = (sz[9:0] == 10'd0) ? 21'd1024 : {11'd0, sz[9:0]};
    h  = (sz[24:16] == 9'd0) ? 21'd512 : {12'd0, sz[24:16]};
    px = w * h;
    return TOT_W'((px + 21'd1) >> 1);
  endfunction
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  parameter int PEEK  = 4,
  parameter int PW    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic [PW-1:0]                pop_n,
  output logic [PEEK*W-1:0]            peek,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      rp  <= rp + AW'(pop_n);
      cnt <= cnt + CW'(push) - CW'(pop_n);
    end
  end

  for (genvar i = 0; i < PEEK; i++) begin : g_peek
    assign peek[i*W +: W] = mem[rp + AW'(i)];
  end
endmodule

// File: rtl/cmd_len_dec.sv
module cmd_len_dec
  import cmd_pkg::*;
#(
  parameter int PLEN_W = 4,
  parameter int SLOTS  = 4,
  parameter int TW     = 3
) (
  input  logic [31:0]       head,
  input  logic [31:0]       size_w,
  input  logic [PLEN_W-1:0] prim_len,
  output kind_e             kind,
  output logic [TOT_W-1:0]  need,
  output logic [TOT_W-1:0]  gate,
  output logic [TW-1:0]     take,
  output logic [TOT_W-1:0]  rest
);
  logic [PLEN_W-1:0] plen;

  always_comb begin
    kind = op_kind(head[31:24]);
    plen = (prim_len == '0) ? PLEN_W'(1) : prim_len;
    case (kind)
      K_FILL:  need = TOT_W'(3);
      K_COPY:  need = TOT_W'(4);
      K_DRAW:  need = TOT_W'(plen);
      K_UP:    need = TOT_W'(3) + up_payload(size_w);
      K_RD:    need = TOT_W'(3);
      default: need = TOT_W'(1);
    endcase
    gate = (kind == K_UP) ? TOT_W'(3) : need;
    take = (gate > TOT_W'(SLOTS)) ? TW'(SLOTS) : TW'(gate);
    rest = need - TOT_W'(take);
  end
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter int          PLEN_W   = 4,
  parameter int          SLOTS    = 4,
  parameter logic [7:0]  CLR_CODE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           in_word,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  side_valid,
  input  logic [7:0]            side_code,
  output logic [7:0]            head_op,
  input  logic [PLEN_W-1:0]     prim_len,
  input  logic                  rd_done,
  output logic                  exec_valid,
  output logic [7:0]            exec_op,
  output logic [SLOTS*32-1:0]   exec_words,
  output logic                  tail_valid,
  output logic [31:0]           tail_word,
  output logic                  cmd_ready,
  output logic                  dma_ready
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(SLOTS+1);

  st_e                 st_q;
  logic [TOT_W-1:0]    total_q, remain_q;
  logic [CW-1:0]       cnt;
  logic [SLOTS*32-1:0] pk, slot_words;
  kind_e               kind;
  logic [TOT_W-1:0]    need, gate, rest;
  logic [TW-1:0]       take, pop_n;
  logic                push, side_clr, idle_like, fire, stream;

  cmd_fifo #(.DEPTH(DEPTH), .W(32), .PEEK(SLOTS), .PW(TW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(side_clr), .push(push), .din(in_word),
    .pop_n(pop_n), .peek(pk), .cnt(cnt)
  );

  cmd_len_dec #(.PLEN_W(PLEN_W), .SLOTS(SLOTS), .TW(TW)) u_dec (
    .head(pk[31:0]), .size_w(pk[2*32 +: 32]), .prim_len(prim_len),
    .kind(kind), .need(need), .gate(gate), .take(take), .rest(rest)
  );

  assign head_op   = pk[31:24];
  assign in_ready  = cnt < CW'(DEPTH);
  assign push      = in_valid && in_ready;
  assign side_clr  = side_valid && (side_code == CLR_CODE);
  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_WAIT);
  assign fire      = idle_like && (cnt != '0) && (TOT_W'(cnt) >= gate);
  assign stream    = ((st_q == ST_EXE) || (st_q == ST_WR)) && (cnt != '0);
  assign pop_n     = fire ? take : (stream ? TW'(1) : '0);
  assign cmd_ready = (st_q == ST_IDLE);
  assign dma_ready = (st_q == ST_IDLE) || ((st_q != ST_RD) && (total_q != '0));

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      slot_words[i*32 +: 32] = (TW'(i) < take) ? pk[i*32 +: 32] : 32'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      total_q    <= '0;
      remain_q   <= '0;
      exec_valid <= 1'b0;
      exec_op    <= '0;
      exec_words <= '0;
      tail_valid <= 1'b0;
      tail_word  <= '0;
    end else if (side_clr) begin
      st_q       <= ST_IDLE;
      total_q    <= '0;
      remain_q   <= '0;
      exec_valid <= 1'b0;
      tail_valid <= 1'b0;
    end else begin
      exec_valid <= fire;
      tail_valid <= stream;
      if (fire) begin
        exec_op    <= pk[31:24];
        exec_words <= slot_words;
        if (kind == K_RD) begin
          st_q    <= ST_RD;
          total_q <= '0;
        end else if (rest != '0) begin
          st_q     <= (kind == K_UP) ? ST_WR : ST_EXE;
          total_q  <= need;
          remain_q <= rest;
        end else begin
          st_q    <= ST_IDLE;
          total_q <= '0;
        end
      end else if (idle_like && cnt != '0) begin
        st_q    <= ST_WAIT;
        total_q <= gate;
      end else if (stream) begin
        tail_word <= pk[31:0];
        remain_q  <= remain_q - TOT_W'(1);
        if (remain_q == TOT_W'(1)) begin
          st_q    <= ST_IDLE;
          total_q <= '0;
        end
      end else if (st_q == ST_RD && rd_done) begin
        st_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk
  import cmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input st_e           st,
  input logic [CW-1:0] cnt,
  input logic          in_ready,
  input logic          exec_valid,
  input logic          tail_valid,
  input logic          cmd_ready,
  input logic          dma_ready,
  input logic          side_clr
);
  // R9
  clr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    side_clr |=> (cnt == '0) && cmd_ready && !exec_valid && !tail_valid);

  // R7
  read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |=> !exec_valid && !tail_valid);

  // R7
  read_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |-> !cmd_ready && !dma_ready);

  // R4
  wait_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !cmd_ready && dma_ready);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !in_ready);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_valid && tail_valid));

  // R5
  tail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_valid |-> ($past(st) == ST_EXE) || ($past(st) == ST_WR));
endmodule

bind cmd_dispatch cmd_dispatch_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .cnt(cnt), .in_ready(in_ready),
  .exec_valid(exec_valid), .tail_valid(tail_valid), .cmd_ready(cmd_ready),
  .dma_ready(dma_ready), .side_clr(side_clr)
);

// File: tb/test_cmd_dispatch.sv
module test_cmd_dispatch;
  localparam int DEPTH = 16;
  localparam int SL    = 4;
  localparam int PLW   = 4;
  localparam int EVN   = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] in_word = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic side_valid = 1'b0;
  logic [7:0] side_code = '0;
  logic [7:0] head_op;
  logic [PLW-1:0] prim_len;
  logic rd_done = 1'b0;
  logic exec_valid;
  logic [7:0] exec_op;
  logic [SL*32-1:0] exec_words;
  logic tail_valid;
  logic [31:0] tail_word;
  logic cmd_ready, dma_ready;

  always #10 clk = ~clk;

  // draw length lookup: low nibble of a draw opcode
  assign prim_len = (head_op[7:5] == 3'b001 || head_op[7:5] == 3'b010 ||
                     head_op[7:5] == 3'b011) ? head_op[3:0] : 4'd0;

  cmd_dispatch #(.DEPTH(DEPTH), .PLEN_W(PLW), .SLOTS(SL)) i_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .side_valid(side_valid), .side_code(side_code),
    .head_op(head_op), .prim_len(prim_len), .rd_done(rd_done),
    .exec_valid(exec_valid), .exec_op(exec_op), .exec_words(exec_words),
    .tail_valid(tail_valid), .tail_word(tail_word),
    .cmd_ready(cmd_ready), .dma_ready(dma_ready)
  );

  int n_chk = 0, n_fail = 0;
  logic [127:0] ev_w [EVN];
  logic [7:0]   ev_op [EVN];
  bit           ev_tail [EVN];
  string        ev_tag [EVN];
  int ev_n = 0, ev_rd = 0;
  int gap_max = 2;
  int rd_delay = 3;
  int rd_cnt = 0;
  bit rd_pending = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_payload(input logic [31:0] w2);
    int ww, hh;
    ww = (w2[9:0] == 0) ? 1024 : int'(w2[9:0]);
    hh = (w2[24:16] == 0) ? 512 : int'(w2[24:16]);
    return (ww * hh + 1) / 2;
  endfunction

  task automatic expect_exec(input logic [7:0] op, input logic [127:0] w);
    ev_w[ev_n] = w; ev_op[ev_n] = op; ev_tail[ev_n] = 1'b0; ev_tag[ev_n] = "R3";
    ev_n++;
  endtask

  task automatic expect_tail(input logic [31:0] w, input string tag);
    ev_w[ev_n] = {96'd0, w}; ev_op[ev_n] = '0; ev_tail[ev_n] = 1'b1; ev_tag[ev_n] = tag;
    ev_n++;
  endtask

  task automatic push_w(input logic [31:0] w);
    in_word = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (gap_max > 0) repeat ($urandom_range(gap_max, 0)) @(negedge clk);
  endtask

  // fixed-length packet, len <= 4
  task automatic pkt_fixed(input logic [7:0] op, input int len);
    logic [31:0] pw [4];
    logic [127:0] ex;
    ex = '0;
    for (int i = 0; i < len; i++) begin
      pw[i] = (i == 0) ? {op, 24'($urandom)} : $urandom;
      ex[i*32 +: 32] = pw[i];
    end
    expect_exec(op, ex);
    for (int i = 0; i < len; i++) push_w(pw[i]);
  endtask

  task automatic pkt_draw(input logic [3:0] nib);
    logic [31:0] pw [16];
    logic [127:0] ex;
    logic [7:0] op;
    int len;
    op = {3'($urandom_range(3, 1)), 1'($urandom), nib};
    len = (nib == 0) ? 1 : int'(nib);
    ex = '0;
    for (int i = 0; i < len; i++) begin
      pw[i] = (i == 0) ? {op, 24'($urandom)} : $urandom;
      if (i < 4) ex[i*32 +: 32] = pw[i];
    end
    expect_exec(op, ex);
    for (int i = 4; i < len; i++) expect_tail(pw[i], "R6");
    for (int i = 0; i < len; i++) push_w(pw[i]);
  endtask

  task automatic pkt_upload(input logic [31:0] w2);
    logic [31:0] w0, w1, pix;
    int n;
    w0 = {3'b101, 5'($urandom), 24'($urandom)};
    w1 = $urandom;
    n = exp_payload(w2);
    expect_exec(w0[31:24], {32'd0, w2, w1, w0});
    push_w(w0); push_w(w1); push_w(w2);
    for (int i = 0; i < n; i++) begin
      pix = $urandom;
      expect_tail(pix, "R5");
      push_w(pix);
    end
  endtask

  task automatic drain();
    while (ev_rd != ev_n || rd_pending) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic side_pulse(input logic [7:0] code);
    side_valid = 1'b1;
    side_code = code;
    @(negedge clk);
    side_valid = 1'b0;
  endtask

  // output monitor and readout engine model
  always @(negedge clk) begin
    if (rd_done) rd_done = 1'b0;
    if (rst_n) begin
      if (rd_pending && (exec_valid || tail_valid))
        chk(1'b0, "R7 output during readout", {126'd0, exec_valid, tail_valid}, 128'd0);
      if (rd_pending) begin
        if (rd_cnt == 0) begin
          rd_done = 1'b1;
          rd_pending = 1'b0;
        end else rd_cnt--;
      end
      if (exec_valid) begin
        if (ev_rd < ev_n && !ev_tail[ev_rd]) begin
          chk(exec_op == ev_op[ev_rd] && exec_words == ev_w[ev_rd], "R3 strobe",
              {exec_op, exec_words[119:0]}, {ev_op[ev_rd], ev_w[ev_rd][119:0]});
          ev_rd++;
        end else chk(1'b0, "R3 unexpected strobe", {120'd0, exec_op}, 128'd0);
        if (exec_op[7:5] == 3'b110) begin
          chk(!cmd_ready && !dma_ready, "R7 status", {126'd0, cmd_ready, dma_ready}, 128'd0);
          rd_pending = 1'b1;
          rd_cnt = rd_delay;
        end
      end
      if (tail_valid) begin
        if (ev_rd < ev_n && ev_tail[ev_rd]) begin
          chk(tail_word == ev_w[ev_rd][31:0], ev_tag[ev_rd], {96'd0, tail_word}, ev_w[ev_rd]);
          ev_rd++;
        end else chk(1'b0, "R5 unexpected tail", {96'd0, tail_word}, 128'd0);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R3 watchdog", 128'd0, 128'd1);
    report();
    $finish;
  end

  initial begin
    logic [31:0] f0, f1, f2;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(in_ready && cmd_ready && dma_ready && !exec_valid && !tail_valid, "R1 reset",
        {123'd0, in_ready, cmd_ready, dma_ready, exec_valid, tail_valid}, 128'h1c);

    // R4: partial fill waits; R9: foreign side code ignored
    gap_max = 0;
    f0 = {8'h02, 24'($urandom)}; f1 = $urandom; f2 = $urandom;
    expect_exec(8'h02, {32'd0, f2, f1, f0});
    push_w(f0); push_w(f1);
    repeat (5) @(negedge clk);
    chk(!cmd_ready && dma_ready, "R4 waiting status", {126'd0, cmd_ready, dma_ready}, 128'd1);
    side_pulse(8'h02);
    repeat (2) @(negedge clk);
    chk(!cmd_ready && dma_ready, "R9 other side code", {126'd0, cmd_ready, dma_ready}, 128'd1);
    push_w(f2);
    drain();

    // R9: clear discards a partial packet
    push_w({8'h02, 24'h123456}); push_w(32'h0bad_0bad);
    side_pulse(8'h01);
    chk(cmd_ready && dma_ready && in_ready, "R9 cleared",
        {125'd0, cmd_ready, dma_ready, in_ready}, 128'd7);
    pkt_fixed(8'h00, 1);
    drain();

    // R2 / R6 draw length corners
    pkt_draw(4'd0);
    pkt_draw(4'd15);
    pkt_draw(4'd5);
    drain();

    // R5 upload corners: odd pixel count, zero width, zero height, noise bits
    pkt_upload({7'h55, 9'd3, 6'h2a, 10'd3});
    pkt_upload({7'h00, 9'd1, 6'h00, 10'd0});
    pkt_upload({7'h7f, 9'd0, 6'h3f, 10'd3});
    drain();

    // R8: readout stall fills the queue
    rd_delay = 60;
    pkt_fixed({3'b110, 5'd5}, 3);
    for (int i = 0; i < DEPTH; i++) pkt_fixed(8'h00, 1);
    chk(!in_ready, "R8 full queue", {127'd0, in_ready}, 128'd0);
    pkt_fixed(8'hE1, 1);
    drain();
    rd_delay = 3;

    // random mix
    gap_max = 2;
    for (int p = 0; p < 150; p++) begin
      case ($urandom_range(5, 0))
        0: begin
          case ($urandom_range(3, 0))
            0: pkt_fixed(8'h00, 1);
            1: pkt_fixed(8'h01, 1);
            2: pkt_fixed(8'hE3, 1);
            default: pkt_fixed(8'h1F, 1);
          endcase
        end
        1: pkt_fixed(8'h02, 3);
        2: pkt_fixed({3'b100, 5'($urandom)}, 4);
        3: pkt_draw(4'($urandom));
        4: pkt_upload({7'($urandom), 9'($urandom_range(3, 1)), 6'($urandom), 10'($urandom_range(4, 1))});
        default: pkt_fixed({3'b110, 5'($urandom)}, 3);
      endcase
    end
    drain();
    chk(ev_rd == ev_n, "R3 all packets executed", 128'(ev_rd), 128'(ev_n));
    report();
    $finish;
  end
endmodule